// File: doc/BRIEF.md
# Distributed-Parity Stripe Write Controller

This controller sits in front of an array of N+1 storage units. Each unit is modelled as a synchronous, word-addressed memory. All units share one request/acknowledge bus, and a unit-select field on that bus picks the unit. A host request carries a logical block number and a direction. The controller divides the logical block number into a stripe and a slot within the stripe. The stripe that holds parity moves to a different unit from one stripe to the next, so parity traffic is spread over every unit. A block is moved as a burst of `BLK_BYTES*8/W` words, and each word is its own handshake.

A single-block write is a read-modify-write of parity. The controller reads the old data and the old parity, then writes the new data and the new parity. It holds the partial XOR in an internal block buffer. The new data words are pulled from the host by word index.

A read goes only to the unit that holds the block, and the words come back through the buffer. The host supplies a failure mask. If the unit that holds the requested block is marked failed, the controller reads every other unit in turn and returns the XOR of their blocks. An operation that cannot be carried out safely ends with a one-cycle error pulse in place of the done pulse.

Top module: `stripe_ctl`

## Requirements
- R1: With N data units, stripe s = lba / N and slot k = lba mod N. The parity unit is p = N − (s mod (N+1)). The data unit is k when k < p, otherwise k+1. Every storage word address is s·BW + i, where i is the word index and BW is the number of words in a block.
- R2: A write (host_we = 1) issues four bursts of BW accesses in this order: reads of the data unit, reads of the parity unit, writes of the data unit, writes of the parity unit. Within each burst, i rises from 0 to BW−1. No read follows a write inside one operation.
- R3: After a write, the data unit holds the host words. Each parity word equals old parity XOR old data XOR new data.
- R4: A read (host_we = 0) whose data unit is not marked failed reads only that unit, word by word. It then presents the block on rd_data with rd_valid high for BW consecutive cycles, with rd_idx running 0..BW−1.
- R5: A read whose data unit is the one failed unit reads every other unit in ascending unit order. It presents the XOR of their blocks, which is the lost block. A failed unit that is not the data unit does not change a read.
- R6: When two or more bits of fail_mask are set, a request of either kind raises err for one cycle and makes no storage access.
- R7: A write whose data unit or parity unit is marked failed raises err for one cycle and makes no storage access. A write where some other unit is failed proceeds normally.
- R8: After reset, busy, done, err and mem_req are low. done pulses for exactly one cycle when an operation completes: after the last parity write is acknowledged, or after the last read word is presented. done and err are never high together. A request raised while busy is ignored.
- R9: While mem_req is high and mem_ack is low, mem_unit, mem_addr and mem_we hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, sampled only while idle |
| host_we | input | 1 | 1 = write block, 0 = read block |
| host_lba | input | LBA_W | Logical block number |
| fail_mask | input | N+1 | One bit per unit, 1 = unit failed |
| host_widx | output | log2(BW) | Index of the write word the host must present |
| host_wdata | input | W | Write word selected by host_widx |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |
| rd_valid | output | 1 | Read word valid |
| rd_idx | output | log2(BW) | Index of the read word |
| rd_data | output | W | Read word |
| mem_req | output | 1 | Storage access request |
| mem_we | output | 1 | Storage access is a write |
| mem_unit | output | log2(N+1) | Selected unit |
| mem_addr | output | LBA_W+log2(BW) | Word address inside the unit |
| mem_wdata | output | W | Storage write word |
| mem_ack | input | 1 | Storage acknowledge, one word per cycle it is high |
| mem_rdata | input | W | Storage read word, valid while mem_ack is high |

## Verification
The assertions assume a storage side that raises mem_ack only while mem_req is high. They also assume that each acknowledge is consumed at the next edge. The bench's memory model decides each acknowledge from the request it sees in that same cycle. It inserts a wait of zero to two cycles from a fixed pattern, so back-to-back and stretched handshakes both occur. The host holds fail_mask steady for the whole operation and presents host_wdata as a pure function of host_widx, which is what the datapath relies on. Every logical block is swept under each single-unit failure and under the refused configurations.

// File: rtl/stripe_ctl.sv
module stripe_ctl #(
  parameter int NU        = 4,
  parameter int W         = 32,
  parameter int BLK_BYTES = 512,
  parameter int LBA_W     = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  host_req,
  input  logic                                  host_we,
  input  logic [LBA_W-1:0]                      host_lba,
  input  logic [NU:0]                           fail_mask,
  output logic [$clog2(BLK_BYTES*8/W)-1:0]      host_widx,
  input  logic [W-1:0]                          host_wdata,
  output logic                                  busy,
  output logic                                  done,
  output logic                                  err,
  output logic                                  rd_valid,
  output logic [$clog2(BLK_BYTES*8/W)-1:0]      rd_idx,
  output logic [W-1:0]                          rd_data,
  output logic                                  mem_req,
  output logic                                  mem_we,
  output logic [$clog2(NU+1)-1:0]               mem_unit,
  output logic [LBA_W+$clog2(BLK_BYTES*8/W)-1:0] mem_addr,
  output logic [W-1:0]                          mem_wdata,
  input  logic                                  mem_ack,
  input  logic [W-1:0]                          mem_rdata
);
  localparam int NUNIT = NU + 1;
  localparam int UW    = $clog2(NUNIT);
  localparam int BW    = BLK_BYTES * 8 / W;
  localparam int CW    = $clog2(BW);

  typedef enum logic [2:0] {S_IDLE, S_RDD, S_RDP, S_WRD, S_WRP, S_RD, S_OUT} st_t;
  st_t st;

  logic [LBA_W-1:0] stripe;
  logic [UW-1:0]    du, pu, cu;
  logic [CW-1:0]    cnt;
  logic             first, degr;
  logic [W-1:0]     acc [BW];

  logic [LBA_W-1:0] s_c, slot_c, pmod_c;
  logic [UW-1:0]    p_c, d_c;
  logic             multi_fail;
  assign s_c        = host_lba / LBA_W'(NU);
  assign slot_c     = host_lba % LBA_W'(NU);
  assign pmod_c     = s_c % LBA_W'(NUNIT);
  assign p_c        = UW'(NU) - UW'(pmod_c);
  assign d_c        = (UW'(slot_c) < p_c) ? UW'(slot_c) : UW'(slot_c) + UW'(1);
  assign multi_fail = $countones(fail_mask) > 1;

  logic          last;
  logic [UW:0]   nx1, nx2;
  logic          sweep_end;
  assign last      = cnt == CW'(BW - 1);
  assign nx1       = {1'b0, cu} + (UW+1)'(1);
  assign nx2       = (nx1 == {1'b0, du}) ? nx1 + (UW+1)'(1) : nx1;
  assign sweep_end = !degr || (nx2 > (UW+1)'(NU));

  assign busy      = st != S_IDLE;
  assign mem_req   = st inside {S_RDD, S_RDP, S_WRD, S_WRP, S_RD};
  assign mem_we    = st inside {S_WRD, S_WRP};
  assign mem_unit  = (st == S_RDD || st == S_WRD) ? du : (st == S_RD) ? cu : pu;
  assign mem_addr  = {stripe, cnt};
  assign mem_wdata = (st == S_WRD) ? host_wdata : acc[cnt];
  assign host_widx = cnt;
  assign rd_valid  = st == S_OUT;
  assign rd_idx    = cnt;
  assign rd_data   = acc[cnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      stripe <= '0;
      du <= '0;
      pu <= '0;
      cu <= '0;
      cnt <= '0;
      first <= 1'b0;
      degr <= 1'b0;
      done <= 1'b0;
      err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (host_req) begin
          stripe <= s_c;
          du <= d_c;
          pu <= p_c;
          cnt <= '0;
          first <= 1'b1;
          if (multi_fail) err <= 1'b1;
          else if (host_we) begin
            if (fail_mask[d_c] || fail_mask[p_c]) err <= 1'b1;
            else st <= S_RDD;
          end else begin
            degr <= fail_mask[d_c];
            cu <= fail_mask[d_c] ? ((d_c == '0) ? UW'(1) : '0) : d_c;
            st <= S_RD;
          end
        end
        S_RDD, S_RDP, S_WRD, S_WRP: if (mem_ack) begin
          cnt <= cnt + CW'(1);
          if (last) begin
            case (st)
              S_RDD:   st <= S_RDP;
              S_RDP:   st <= S_WRD;
              S_WRD:   st <= S_WRP;
              default: begin st <= S_IDLE; done <= 1'b1; end
            endcase
          end
        end
        S_RD: if (mem_ack) begin
          cnt <= cnt + CW'(1);
          if (last) begin
            first <= 1'b0;
            if (sweep_end) st <= S_OUT;
            else cu <= nx2[UW-1:0];
          end
        end
        S_OUT: begin
          cnt <= cnt + CW'(1);
          if (last) begin st <= S_IDLE; done <= 1'b1; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_ack) begin
      case (st)
        S_RDD:   acc[cnt] <= mem_rdata ^ host_wdata;
        S_RDP:   acc[cnt] <= acc[cnt] ^ mem_rdata;
        S_RD:    acc[cnt] <= first ? mem_rdata : (acc[cnt] ^ mem_rdata);
        default: ;
      endcase
    end
  end

  a_r1_unit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_unit <= UW'(NU)));
  a_r2_reads_before_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> !(mem_req && !mem_we));
  a_r4_out_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> (rd_idx == $past(rd_idx) + CW'(1)));
  a_r6_err_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_unit) && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/tb_stripe_ctl.sv
module tb_stripe_ctl;
  localparam int NU = 3, W = 8, BB = 4, LW = 4;
  localparam int NUNIT = NU + 1, BW = BB * 8 / W, CW = $clog2(BW), UW = $clog2(NUNIT);
  localparam int AW = LW + CW, NLBA = 1 << LW;

  logic clk = 0, rst_n = 0;
  logic host_req = 0, host_we = 0;
  logic [LW-1:0] host_lba = '0;
  logic [NU:0] fail_mask = '0;
  logic [CW-1:0] host_widx;
  logic [W-1:0] host_wdata;
  logic busy, done, err, rd_valid, mem_req, mem_we, mem_ack = 0;
  logic [CW-1:0] rd_idx;
  logic [W-1:0] rd_data, mem_wdata, mem_rdata = '0;
  logic [UW-1:0] mem_unit;
  logic [AW-1:0] mem_addr;

  always #5 clk = ~clk;

  stripe_ctl #(.NU(NU), .W(W), .BLK_BYTES(BB), .LBA_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we), .host_lba(host_lba),
    .fail_mask(fail_mask), .host_widx(host_widx), .host_wdata(host_wdata), .busy(busy),
    .done(done), .err(err), .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_unit(mem_unit), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  logic [W-1:0] mem [NUNIT][1 << AW];
  logic [W-1:0] gdat [NLBA][BW];
  logic [W-1:0] wbuf [BW];
  logic [W-1:0] rdbuf [BW];
  int lg_we [64], lg_u [64], lg_a [64];
  int lg_n = 0, waitc = 0, pat = 0;
  int tests = 0, fails = 0;

  assign host_wdata = wbuf[host_widx];

  always @(negedge clk) begin
    if (rd_valid) rdbuf[rd_idx] = rd_data;
    if (mem_req) begin
      if (waitc == 0) begin
        mem_ack = 1;
        if (mem_we) mem[mem_unit][mem_addr] = mem_wdata;
        else mem_rdata = mem[mem_unit][mem_addr];
        if (lg_n < 64) begin
          lg_we[lg_n] = int'(mem_we); lg_u[lg_n] = int'(mem_unit); lg_a[lg_n] = int'(mem_addr);
        end
        lg_n++;
        pat++;
        waitc = (pat * 7) % 3;
      end else begin
        mem_ack = 0;
        waitc--;
      end
    end else mem_ack = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int punit(input int lba);
    return NU - ((lba / NU) % NUNIT);
  endfunction
  function automatic int dunit(input int lba);
    int k = lba % NU;
    return (k < punit(lba)) ? k : k + 1;
  endfunction

  task automatic do_op(input bit we, input int lba, input logic [NU:0] mask, input int intrude,
                       output bit gd, output bit ge);
    lg_n = 0;
    @(negedge clk);
    host_req = 1; host_we = we; host_lba = LW'(lba); fail_mask = mask;
    @(negedge clk);
    host_req = 0;
    if (intrude >= 0) begin
      @(negedge clk); @(negedge clk);
      host_req = 1; host_we = 1; host_lba = LW'(intrude);
      @(negedge clk);
      host_req = 0;
    end
    gd = 0; ge = 0;
    for (int c = 0; c < 1000 && !gd && !ge; c++) begin
      if (done) gd = 1;
      if (err) ge = 1;
      if (!gd && !ge) @(negedge clk);
    end
    if (!gd && !ge) chk(0, "R8 timeout", 0, 1);
    if (gd) begin
      @(negedge clk);
      chk(done == 0, "R8 done one cycle", int'(done), 0);
    end
  endtask

  task automatic read_blk(input int lba, input logic [NU:0] mask);
    bit gd, ge, ok;
    int d, s, n, bad, ue, ie;
    d = dunit(lba); s = lba / NU;
    do_op(0, lba, mask, -1, gd, ge);
    chk(gd && !ge, "R4 read completes", int'(gd), 1);
    bad = -1;
    for (int i = 0; i < BW; i++) if (rdbuf[i] !== gdat[lba][i] && bad < 0) bad = i;
    chk(bad < 0, mask[d] ? "R5 rebuilt data" : "R4 read data", bad, -1);
    n = mask[d] ? NU * BW : BW;
    ok = (lg_n == n);
    for (int k = 0; k < n && ok; k++) begin
      ue = mask[d] ? (((k / BW) < d) ? (k / BW) : (k / BW) + 1) : d;
      ie = k % BW;
      if (lg_we[k] != 0 || lg_u[k] != ue || lg_a[k] != s * BW + ie) ok = 0;
    end
    chk(ok, mask[d] ? "R5 survivor sweep" : "R1 R4 single unit access", lg_n, n);
  endtask

  task automatic write_blk(input int lba, input logic [NU:0] mask, input int seed, input int intrude);
    bit gd, ge, ok;
    int d, p, s, ph, ue, bad;
    logic [W-1:0] od [BW];
    logic [W-1:0] op [BW];
    d = dunit(lba); p = punit(lba); s = lba / NU;
    for (int i = 0; i < BW; i++) begin
      wbuf[i] = W'(lba * 53 + i * 29 + seed);
      od[i] = mem[d][s * BW + i];
      op[i] = mem[p][s * BW + i];
    end
    do_op(1, lba, mask, intrude, gd, ge);
    chk(gd && !ge, "R2 write completes", int'(gd), 1);
    ok = (lg_n == 4 * BW);
    for (int k = 0; k < 4 * BW && ok; k++) begin
      ph = k / BW;
      ue = (ph == 0 || ph == 2) ? d : p;
      if (lg_we[k] != int'(ph >= 2) || lg_u[k] != ue || lg_a[k] != s * BW + (k % BW)) ok = 0;
    end
    chk(ok, intrude >= 0 ? "R8 busy ignores request" : "R1 R2 access order", lg_n, 4 * BW);
    bad = -1;
    for (int i = 0; i < BW; i++)
      if ((mem[d][s * BW + i] !== wbuf[i] || mem[p][s * BW + i] !== (op[i] ^ od[i] ^ wbuf[i])) && bad < 0)
        bad = i;
    chk(bad < 0, "R3 data and parity", bad, -1);
    for (int i = 0; i < BW; i++) gdat[lba][i] = wbuf[i];
  endtask

  task automatic refused(input bit we, input int lba, input logic [NU:0] mask, input string req);
    bit gd, ge;
    do_op(we, lba, mask, -1, gd, ge);
    chk(ge && !gd, req, int'(ge), 1);
    repeat (3) @(negedge clk);
    chk(lg_n == 0 && !busy, req, lg_n, 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL R8 watchdog expired actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] par;
    for (int u = 0; u < NUNIT; u++) for (int a = 0; a < (1 << AW); a++) mem[u][a] = '0;
    for (int l = 0; l < NLBA; l++) for (int i = 0; i < BW; i++) begin
      gdat[l][i] = W'(l * 37 + i * 11 + 5);
      mem[dunit(l)][(l / NU) * BW + i] = gdat[l][i];
    end
    for (int s = 0; s * NU < NLBA; s++) for (int i = 0; i < BW; i++) begin
      par = '0;
      for (int k = 0; k < NU; k++) if (s * NU + k < NLBA) par ^= gdat[s * NU + k][i];
      mem[punit(s * NU)][s * BW + i] = par;
    end
    for (int i = 0; i < BW; i++) wbuf[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !err && !mem_req, "R8 reset state", int'(busy), 0);

    for (int l = 0; l < NLBA; l++) read_blk(l, '0);
    for (int l = 0; l < NLBA; l++) write_blk(l, '0, 3, -1);
    for (int l = 0; l < NLBA; l++) read_blk(l, '0);
    for (int f = 0; f < NUNIT; f++)
      for (int l = 0; l < NLBA; l++) read_blk(l, (NU+1)'(1) << f);

    for (int l = 0; l < NLBA; l++) begin
      refused(1, l, (NU+1)'(1) << dunit(l), "R7 write to failed data unit");
      refused(1, l, (NU+1)'(1) << punit(l), "R7 write with failed parity unit");
    end
    refused(0, 5, (NU+1)'(3), "R6 two failed units on read");
    refused(1, 7, (NU+1)'(5), "R6 two failed units on write");

    for (int l = 0; l < NLBA; l++) begin
      int o = 0;
      while (o == dunit(l) || o == punit(l)) o++;
      write_blk(l, (NU+1)'(1) << o, 9, -1);
    end
    write_blk(4, '0, 17, 10);
    for (int f = 0; f < NUNIT; f++)
      for (int l = 0; l < NLBA; l++) read_blk(l, (NU+1)'(1) << f);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule